// File: doc/BRIEF.md
# Transactional Shared-Memory Controller

This block sits between four processor request streams and an on-chip main memory. It gives each processor transactional access to shared words. A processor issues loads and stores against shared addresses and then asks to commit. The controller decides whether the whole group of accesses becomes visible in memory at once or is thrown away. Software retries a rejected transaction. It does not need locks.

Shared words are staged in one small fully associative cache. Each cache entry records, for every processor, whether that processor has read it and whether it has written it. A store collides when any other processor already holds a read or write mark on the same entry. The processor that collides is not told at that moment: it learns the outcome only from the reply to its commit request. Each processor has an address log that records the entries it touched. At commit the controller walks that log to write back or discard the processor's entries and to clear its marks. Requests from the four ports are served one at a time. A round-robin arbiter picks which port is served next.

Top module: `txn_mem_ctrl`

## Requirements
- R1: A load (in_ctl=0, word bit 31=0, address in bits AW-1:0) returns the cached word on a hit, otherwise the main-memory word. On a miss the word is placed in a free cache entry and the requester's read mark is set.
- R2: A store (in_ctl=0, word bit 31=1, address in bits AW-1:0, followed by a data word) with no collision writes the data into the cache entry and sets the requester's write mark. The reply has rsp_ctl=0 and rsp_data=0.
- R3: A store collides when another processor holds a read or write mark on the entry. A colliding store changes nothing in the cache, and that processor's next commit is rejected. At most one processor ever holds a write mark on an entry.
- R4: An accepted commit copies every entry the committer wrote into main memory, so later loads from any port return the new value.
- R5: At commit, an entry that no other processor has marked is freed. An entry that other processors have marked keeps its data and their marks, and only the committer's marks are cleared. A valid bit is never clear on an entry that holds marks.
- R6: A rejected commit writes nothing to main memory and frees every entry the committer wrote, so its stores are never observed.
- R7: If a processor's address log is full on a first access, or a miss finds no free cache entry, that processor's transaction is marked collided and its commit is rejected. No log holds more than FD addresses.
- R8: Only a processor's first access to an entry takes a log slot. Repeated accesses do not fill the log, and a log holding exactly FD addresses still commits.
- R9: When several ports request at once, the port after the one last served is served first, in rising order modulo NP. After reset port 0 has the highest priority. in_rdy is one-hot or zero and only accompanies in_vld.
- R10: A word with in_ctl=1 is a commit. Its reply has rsp_ctl=1 for reject and 0 for accept. Every reply is a one-cycle pulse on the requester's rsp_vld bit, and only one bit is set at a time.
- R11: After reset no reply is pending, in_rdy is low while no port requests, and main memory reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | NP | Per-port request word valid |
| in_ctl | input | NP | Per-port control bit, 1 marks a commit |
| in_data | input | NP*DW | Per-port request word, port p in bits p*DW +: DW |
| in_rdy | output | NP | Per-port word taken this cycle |
| rsp_vld | output | NP | One-cycle reply pulse for the port being answered |
| rsp_ctl | output | 1 | Reply control bit, 1 = commit rejected |
| rsp_data | output | DW | Load data, zero for store and commit replies |

## Verification
The assertions assume that each port follows the request protocol. A port keeps in_vld and its word steady until in_rdy accepts it, sends a store's data word right after the store's address word, and waits for its reply before it starts the next request. The bench keeps to this by running requests through one transfer task that holds each word until it is taken and then waits for the reply pulse. Only the arbitration burst runs four ports in parallel, and there each port still has a single load in flight.

// File: rtl/txn_mem_ctrl.sv
module txn_mem_ctrl #(
  parameter int NP = 4,
  parameter int DW = 32,
  parameter int AW = 10,
  parameter int CN = 64,
  parameter int FD = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    in_vld,
  input  logic [NP-1:0]    in_ctl,
  input  logic [NP*DW-1:0] in_data,
  output logic [NP-1:0]    in_rdy,
  output logic [NP-1:0]    rsp_vld,
  output logic             rsp_ctl,
  output logic [DW-1:0]    rsp_data
);
  localparam int PW  = (NP > 1) ? $clog2(NP) : 1;
  localparam int CIW = (CN > 1) ? $clog2(CN) : 1;
  localparam int FIW = (FD > 1) ? $clog2(FD) : 1;
  localparam int MD  = 1 << AW;
  localparam logic [FIW:0] LOG_FULL = (FIW+1)'(FD);

  typedef enum logic [1:0] {S_IDLE, S_SDAT, S_EXEC, S_CMT} st_t;
  st_t st;

  logic [PW-1:0]  rr, g, pick;
  logic           pick_ok;
  logic           op_st;
  logic [AW-1:0]  addr, key;
  logic [DW-1:0]  wdat, rd;
  logic [FIW:0]   idx;

  logic [CN-1:0]  c_vld;
  logic [AW-1:0]  c_tag [CN];
  logic [DW-1:0]  c_dat [CN];
  logic [NP-1:0]  c_rf  [CN];
  logic [NP-1:0]  c_wf  [CN];

  logic [AW-1:0]  f_mem [NP][FD];
  logic [FIW:0]   f_cnt [NP];
  logic [NP-1:0]  coll;
  logic [DW-1:0]  mem   [MD];

  logic           hit, fr, own, ffull, cmt_end, mem_we;
  logic [CIW-1:0] hi, fi;
  logic [NP-1:0]  gbit, rest;

  always_comb begin
    pick = rr;
    pick_ok = 1'b0;
    for (int k = 1; k <= NP; k++) begin
      if (!pick_ok && in_vld[PW'((int'(rr) + k) % NP)]) begin
        pick = PW'((int'(rr) + k) % NP);
        pick_ok = 1'b1;
      end
    end
  end

  assign gbit   = NP'(1) << g;
  assign in_rdy = (st == S_IDLE && pick_ok) ? (NP'(1) << pick) :
                  (st == S_SDAT) ? (gbit & in_vld) : '0;

  assign key = (st == S_CMT) ? f_mem[g][idx[FIW-1:0]] : addr;

  always_comb begin
    hit = 1'b0; hi = '0; fr = 1'b0; fi = '0;
    for (int i = CN-1; i >= 0; i--) begin
      if (c_vld[i] && c_tag[i] == key) begin
        hit = 1'b1;
        hi = CIW'(i);
      end
      if (!c_vld[i]) begin
        fr = 1'b1;
        fi = CIW'(i);
      end
    end
  end

  assign own     = c_rf[hi][g] | c_wf[hi][g];
  assign rest    = (c_rf[hi] | c_wf[hi]) & ~gbit;
  assign ffull   = f_cnt[g] == LOG_FULL;
  assign cmt_end = idx == f_cnt[g];
  assign mem_we  = st == S_CMT && !cmt_end && hit && !coll[g] && c_wf[hi][g];
  assign rd      = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MD; i++) mem[i] <= '0;
    end else if (mem_we) begin
      mem[key] <= c_dat[hi];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rr <= PW'(NP-1);
      g <= '0;
      op_st <= 1'b0;
      addr <= '0;
      wdat <= '0;
      idx <= '0;
      rsp_vld <= '0;
      rsp_ctl <= 1'b0;
      rsp_data <= '0;
      c_vld <= '0;
      coll <= '0;
      for (int i = 0; i < CN; i++) begin
        c_rf[i] <= '0;
        c_wf[i] <= '0;
      end
      for (int p = 0; p < NP; p++) f_cnt[p] <= '0;
    end else begin
      rsp_vld <= '0;
      case (st)
        S_IDLE: if (pick_ok) begin
          g <= pick;
          rr <= pick;
          op_st <= in_data[pick*DW + DW - 1];
          addr <= in_data[pick*DW +: AW];
          idx <= '0;
          if (in_ctl[pick]) st <= S_CMT;
          else if (in_data[pick*DW + DW - 1]) st <= S_SDAT;
          else st <= S_EXEC;
        end
        S_SDAT: if (in_vld[g]) begin
          wdat <= in_data[g*DW +: DW];
          st <= S_EXEC;
        end
        S_EXEC: begin
          rsp_vld <= gbit;
          rsp_ctl <= 1'b0;
          rsp_data <= op_st ? '0 : (hit ? c_dat[hi] : rd);
          st <= S_IDLE;
          if (hit && op_st && |rest) begin
            coll[g] <= 1'b1;
          end else if (hit && own) begin
            if (op_st) begin
              c_dat[hi] <= wdat;
              c_wf[hi][g] <= 1'b1;
            end
          end else if (ffull || (!hit && !fr)) begin
            coll[g] <= 1'b1;
          end else begin
            f_mem[g][f_cnt[g][FIW-1:0]] <= addr;
            f_cnt[g] <= f_cnt[g] + 1'b1;
            if (hit) begin
              if (op_st) begin
                c_dat[hi] <= wdat;
                c_wf[hi][g] <= 1'b1;
              end else begin
                c_rf[hi][g] <= 1'b1;
              end
            end else begin
              c_vld[fi] <= 1'b1;
              c_tag[fi] <= addr;
              c_dat[fi] <= op_st ? wdat : rd;
              c_rf[fi] <= op_st ? '0 : gbit;
              c_wf[fi] <= op_st ? gbit : '0;
            end
          end
        end
        S_CMT: begin
          if (cmt_end) begin
            rsp_vld <= gbit;
            rsp_ctl <= coll[g];
            rsp_data <= '0;
            coll[g] <= 1'b0;
            f_cnt[g] <= '0;
            st <= S_IDLE;
          end else begin
            if (hit) begin
              if (rest == '0 || (coll[g] && c_wf[hi][g])) begin
                c_vld[hi] <= 1'b0;
                c_rf[hi] <= '0;
                c_wf[hi] <= '0;
              end else begin
                c_rf[hi][g] <= 1'b0;
                c_wf[hi][g] <= 1'b0;
              end
            end
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txn_mem_ctrl_chk.sv
module txn_mem_ctrl_chk #(
  parameter int NP  = 4,
  parameter int CN  = 64,
  parameter int FD  = 16,
  parameter int FIW = 4
)(
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] in_vld,
  input logic [NP-1:0] in_rdy,
  input logic [NP-1:0] rsp_vld,
  input logic [CN-1:0] c_vld,
  input logic [NP-1:0] c_rf  [CN],
  input logic [NP-1:0] c_wf  [CN],
  input logic [FIW:0]  f_cnt [NP]
);
  p_grant_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_rdy));

  p_grant_has_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdy & ~in_vld) == '0);

  p_reply_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_vld));

  p_reply_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld != '0) |=> (rsp_vld == '0));

  for (genvar i = 0; i < CN; i++) begin : g_ent
    p_one_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(c_wf[i]));
    p_flags_need_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !c_vld[i] |-> ((c_rf[i] | c_wf[i]) == '0));
  end

  for (genvar k = 0; k < NP; k++) begin : g_log
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      f_cnt[k] <= (FIW+1)'(FD));
  end
endmodule

bind txn_mem_ctrl txn_mem_ctrl_chk #(.NP(NP), .CN(CN), .FD(FD), .FIW(FIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy), .rsp_vld(rsp_vld),
  .c_vld(c_vld), .c_rf(c_rf), .c_wf(c_wf), .f_cnt(f_cnt)
);

// File: tb/txn_mem_ctrl_tb.sv
`timescale 1ns/1ps
module txn_mem_ctrl_tb;
  localparam int NP = 4, DW = 32, AW = 10, CN = 20, FD = 16;
  localparam int MD = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [NP-1:0] in_vld, in_ctl, in_rdy, rsp_vld;
  logic [NP*DW-1:0] in_data;
  logic rsp_ctl;
  logic [DW-1:0] rsp_data;

  txn_mem_ctrl #(.NP(NP), .DW(DW), .AW(AW), .CN(CN), .FD(FD)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ctl(in_ctl), .in_data(in_data),
    .in_rdy(in_rdy), .rsp_vld(rsp_vld), .rsp_ctl(rsp_ctl), .rsp_data(rsp_data)
  );

  int checks = 0, errors = 0;
  bit mv [MD];
  logic [31:0] md [MD], mm [MD];
  bit [3:0] mr [MD], mw [MD];
  int logn [NP];
  bit cl [NP];
  int occ = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_load(int p, int a);
    logic [31:0] d;
    d = mv[a] ? md[a] : mm[a];
    if (mv[a] && (mr[a][p] | mw[a][p])) return d;
    if (logn[p] == FD || (!mv[a] && occ == CN)) begin cl[p] = 1; return d; end
    logn[p]++;
    if (!mv[a]) begin mv[a] = 1; md[a] = mm[a]; mr[a] = 0; mw[a] = 0; occ++; end
    mr[a][p] = 1;
    return d;
  endfunction

  function automatic void m_store(int p, int a, logic [31:0] d);
    if (mv[a]) begin
      if (((mr[a] | mw[a]) & ~(4'b1 << p)) != 0) begin cl[p] = 1; return; end
      if (mr[a][p] | mw[a][p]) begin md[a] = d; mw[a][p] = 1; return; end
    end
    if (logn[p] == FD || (!mv[a] && occ == CN)) begin cl[p] = 1; return; end
    logn[p]++;
    if (!mv[a]) begin mv[a] = 1; mr[a] = 0; mw[a] = 0; occ++; end
    md[a] = d;
    mw[a][p] = 1;
  endfunction

  function automatic bit m_commit(int p);
    bit rej = cl[p];
    for (int a = 0; a < MD; a++) begin
      if (mv[a] && (mr[a][p] | mw[a][p])) begin
        if (!rej && mw[a][p]) mm[a] = md[a];
        if ((rej && mw[a][p]) || (((mr[a] | mw[a]) & ~(4'b1 << p)) == 0)) begin
          mv[a] = 0; mr[a] = 0; mw[a] = 0; occ--;
        end else begin
          mr[a][p] = 0; mw[a][p] = 0;
        end
      end
    end
    logn[p] = 0;
    cl[p] = 0;
    return rej;
  endfunction

  task automatic xfer(int p, logic [31:0] w, bit c);
    in_vld[p] = 1'b1;
    in_ctl[p] = c;
    in_data[p*DW +: DW] = w;
    #1;
    while (!in_rdy[p]) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_vld[p] = 1'b0;
    in_ctl[p] = 1'b0;
  endtask

  task automatic get_rsp(int p, output logic c, output logic [31:0] d);
    while (!rsp_vld[p]) @(negedge clk);
    c = rsp_ctl;
    d = rsp_data;
    @(posedge clk); #1;
  endtask

  task automatic op_load(int p, int a, string tag, output logic [31:0] d);
    logic c;
    logic [31:0] e;
    @(negedge clk);
    xfer(p, 32'(a), 1'b0);
    get_rsp(p, c, d);
    e = m_load(p, a);
    chk(d === e && c === 1'b0, tag, d, e);
  endtask

  task automatic op_store(int p, int a, logic [31:0] v, string tag);
    logic c;
    logic [31:0] d;
    @(negedge clk);
    xfer(p, 32'h8000_0000 | 32'(a), 1'b0);
    xfer(p, v, 1'b0);
    get_rsp(p, c, d);
    m_store(p, a, v);
    chk(c === 1'b0 && d === 32'h0, tag, {31'h0, c} | d, 32'h0);
  endtask

  task automatic op_commit(int p, int want, string tag);
    logic c;
    logic [31:0] d;
    bit e;
    @(negedge clk);
    xfer(p, 32'h0, 1'b1);
    get_rsp(p, c, d);
    e = m_commit(p);
    if (want >= 0) e = want[0];
    chk(c === e, tag, {31'h0, c}, {31'h0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    time tr [NP];
    void'($urandom(32'd20240611));
    for (int a = 0; a < MD; a++) begin mv[a] = 0; mm[a] = 0; mr[a] = 0; mw[a] = 0; end
    for (int p = 0; p < NP; p++) begin logn[p] = 0; cl[p] = 0; end
    rst_n = 1'b0; in_vld = '0; in_ctl = '0; in_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rsp_vld === '0, "R11 no reply in reset", 32'(rsp_vld), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_rdy === '0 && rsp_vld === '0, "R11 idle after reset", 32'({in_rdy, rsp_vld}), 32'h0);

    // R9 four simultaneous loads, served 0,1,2,3 after reset
    for (int p = 0; p < NP; p++) begin
      automatic int q = p;
      fork
        begin
          logic c;
          logic [31:0] dd;
          xfer(q, 32'(100 + q), 1'b0);
          get_rsp(q, c, dd);
          tr[q] = $time;
          chk(dd === 32'h0, "R11 memory reads zero", dd, 32'h0);
        end
      join_none
    end
    wait fork;
    for (int p = 0; p < NP; p++) void'(m_load(p, 100 + p));
    for (int p = 1; p < NP; p++)
      chk(tr[p] > tr[p-1], "R9 round-robin order", 32'(p), 32'(p - 1));
    for (int p = 0; p < NP; p++) op_commit(p, 0, "R8 commit after burst");

    // R2 R4 store then commit, visible to another port
    op_store(0, 5, 32'h1234, "R2 store ack");
    op_commit(0, 0, "R4 accept");
    op_load(1, 5, "R4 load after commit", d);
    chk(d === 32'h1234, "R4 written back", d, 32'h1234);
    op_commit(1, 0, "R4 accept reader");

    // R3 store collides with other reader
    op_load(0, 7, "R1 load", d);
    op_store(1, 7, 32'hAA, "R3 colliding store ack");
    op_commit(1, 1, "R3 reject collider");
    op_load(0, 7, "R3 store dropped", d);
    chk(d === 32'h0, "R3 cache unchanged", d, 32'h0);
    op_commit(0, 0, "R3 reader accepted");
    op_load(2, 7, "R6 memory unchanged", d);
    chk(d === 32'h0, "R6 no write on reject", d, 32'h0);
    op_commit(2, 0, "R6 accept");

    // R6 rejected commit discards own written entries
    op_store(3, 10, 32'h77, "R2 store");
    op_load(2, 9, "R1 load", d);
    op_store(3, 9, 32'h66, "R3 store onto read entry");
    op_commit(3, 1, "R6 reject");
    op_load(0, 10, "R6 discarded write", d);
    chk(d === 32'h0, "R6 store never seen", d, 32'h0);
    op_store(2, 8, 32'h55, "R2 store");
    op_commit(2, 0, "R4 accept");
    op_commit(0, 0, "R4 accept");
    op_load(1, 8, "R4 new value", d);
    chk(d === 32'h55, "R4 value in memory", d, 32'h55);
    op_commit(1, 0, "R4 accept");

    // R5 shared entry keeps other marks only until their owner commits
    op_load(0, 20, "R1 load", d);
    op_load(1, 20, "R1 load", d);
    op_commit(0, 0, "R5 accept");
    op_store(1, 20, 32'h99, "R5 store after peer commit");
    op_commit(1, 0, "R5 peer marks cleared");
    op_load(2, 20, "R5 visible", d);
    chk(d === 32'h99, "R5 value", d, 32'h99);
    op_commit(2, 0, "R5 accept");

    // R8 repeated access uses one slot
    for (int i = 0; i < 20; i++) op_load(0, 30, "R8 repeat load", d);
    op_commit(0, 0, "R8 repeats accepted");

    // R7 cache full
    for (int i = 0; i < FD; i++) op_load(0, 40 + i, "R1 fill", d);
    for (int i = 0; i < CN - FD; i++) op_load(1, 60 + i, "R1 fill", d);
    op_load(1, 70, "R7 miss with full cache", d);
    op_commit(0, 0, "R8 exactly full log accepted");
    op_commit(1, 1, "R7 cache full reject");

    // R7 log overflow
    for (int i = 0; i <= FD; i++) op_load(2, 80 + i, "R1 log fill", d);
    op_commit(2, 1, "R7 log overflow reject");

    // R5 freed entries reusable to full capacity
    for (int i = 0; i < FD; i++) op_load(1, 200 + i, "R5 refill", d);
    for (int i = 0; i < CN - FD; i++) op_load(3, 240 + i, "R5 refill", d);
    op_commit(1, 0, "R5 capacity back");
    op_commit(3, 0, "R5 capacity back");

    // random mix checked against the model
    for (int i = 0; i < 500; i++) begin
      automatic int p = int'($urandom % NP);
      automatic int r = int'($urandom % 10);
      automatic int a = int'($urandom % 12);
      if (r < 4) op_load(p, a, "R1 random load", d);
      else if (r < 8) op_store(p, a, $urandom, "R2 random store");
      else op_commit(p, -1, "R3 random commit");
    end
    for (int p = 0; p < NP; p++) op_commit(p, -1, "R6 final commit");
    for (int a = 0; a < 12; a++) begin
      op_load(0, a, "R4 final readback", d);
    end
    op_commit(0, -1, "R4 final commit");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule